// File: doc/BRIEF.md
# Secure Command MAC Policy Checker

This block sits beside the command decoder of a contactless card controller running in its strongest protection mode. For every decoded command it reads the command class, whether a command MAC came with it, whether the reader wants a MAC on the response, whether the data travels in plain or encrypted form, and whether the addressed block may be sent in plain. It then decides whether to accept or reject the command and whether the response should get a MAC. The cryptography itself lives elsewhere. This block only enforces the policy.

It also follows the chained-MAC transaction. A first authentication opens a new transaction and zeroes a counter of accepted commands. Responses sent without a MAC leave the earlier reads unverified until a later response carries a MAC that covers them all. If a new authentication arrives while reads are still unverified, the block raises a one-cycle warning.

Top module: `cmd_mac_policy`

## Requirements
- R1: After reset the block is unauthenticated, `txn_count_o` is 0, and `unverified_o`, `res_valid_o` and `auth_warn_o` are 0.
- R2: A command presented before any first authentication is rejected with status 3, and the counter does not change.
- R3: Commands of class write (1), value (2) or other (3) that lack a command MAC (`cmd_mac_i`=0) are rejected with status 1.
- R4: A read (class 0) without a command MAC is accepted only when `allow_unmaced_rd_i`=1. Otherwise it is rejected with status 1.
- R5: A read or write with `plain_i`=1 to a block whose `blk_plain_ok_i`=0 is rejected with status 2. A missing MAC (status 1) takes precedence over this. The plain flag is ignored for value and other commands.
- R6: For an accepted command (status 0), `res_rsp_mac_o` equals the requested `rsp_mac_req_i`. For a rejected command it is 0.
- R7: A first authentication makes the block authenticated, sets the counter to 0 and clears `unverified_o`. A following authentication while authenticated clears `unverified_o` and keeps the counter. A following authentication while unauthenticated is ignored.
- R8: Each accepted command adds one to `txn_count_o`, and rejected commands leave it unchanged. With `SATURATE`=1 the counter holds at 2^CNT_W-1.
- R9: An accepted read with no response MAC sets `unverified_o`. Any accepted command whose response carries a MAC clears it.
- R10: An authentication (first, or following while authenticated) that arrives while `unverified_o` is 1 pulses `auth_warn_o` high for exactly one cycle.
- R11: A command presented in the same cycle as an authentication event is dropped and produces no result.
- R12: Results appear one cycle after `cmd_valid_i`, with `res_valid_o` high for one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_kind_i | input | 2 | Class: 0 read, 1 write, 2 value, 3 other |
| cmd_mac_i | input | 1 | Command carried a MAC |
| rsp_mac_req_i | input | 1 | Reader requests a MAC on the response |
| plain_i | input | 1 | Data is transferred in plain |
| blk_plain_ok_i | input | 1 | Addressed block permits plain transfer |
| allow_unmaced_rd_i | input | 1 | Configuration allows reads without a command MAC |
| auth_first_i | input | 1 | First authentication completed (pulse) |
| auth_follow_i | input | 1 | Following authentication completed (pulse) |
| res_valid_o | output | 1 | Result valid |
| res_status_o | output | 2 | 0 accept, 1 MAC missing, 2 plain denied, 3 not authenticated |
| res_rsp_mac_o | output | 1 | Append a MAC to the response |
| txn_count_o | output | CNT_W | Accepted commands in the current transaction |
| unverified_o | output | 1 | Reads returned without a MAC remain unverified |
| auth_warn_o | output | 1 | Authentication while reads were unverified |

## Verification
The bench builds the block with `CNT_W`=3 and the saturating counter variant, so the counter's ceiling of 7 is reached within a handful of accepted commands and the hold at the limit can be observed directly. The table walk covers every class against the MAC and plain rules, including the precedence between the two rejection causes. The directed part covers the unauthenticated start, the ignored following authentication, the warning pulse, and the collision between a command and an authentication.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

   typedef enum logic [1:0] {
      CK_READ  = 2'd0,
      CK_WRITE = 2'd1,
      CK_VALUE = 2'd2,
      CK_OTHER = 2'd3
   } cmd_kind_e;

   typedef enum logic [1:0] {
      VD_OK      = 2'd0,
      VD_NO_MAC  = 2'd1,
      VD_PLAIN   = 2'd2,
      VD_NO_AUTH = 2'd3
   } verdict_e;

   typedef struct packed {
      cmd_kind_e kind;
      logic      cmd_mac;
      logic      rsp_req;
      logic      plain;
      logic      blk_plain_ok;
   } cmd_req_t;

endpackage

// File: rtl/cmp_rule_eval.sv
module cmp_rule_eval
   import cmp_pkg::*;
(
   input  cmd_req_t req,
   input  logic     authed,
   input  logic     allow_unmaced_rd,
   output verdict_e verdict,
   output logic     accept
);

   logic mac_ok;
   logic plain_applies;
   logic plain_ok;

   always_comb begin
      mac_ok        = req.cmd_mac || ((req.kind == CK_READ) && allow_unmaced_rd);
      plain_applies = (req.kind == CK_READ) || (req.kind == CK_WRITE);
      plain_ok      = !plain_applies || !req.plain || req.blk_plain_ok;
      if (!authed)
         verdict = VD_NO_AUTH;
      else if (!mac_ok)
         verdict = VD_NO_MAC;
      else if (!plain_ok)
         verdict = VD_PLAIN;
      else
         verdict = VD_OK;
      accept = (verdict == VD_OK);
   end

endmodule

// File: rtl/cmp_txn_counter.sv
module cmp_txn_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         always_comb nxt = (count == CNT_MAX) ? count : count + 1'b1;
      end else begin : g_wrap
         always_comb nxt = count + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc)
         count <= nxt;
   end

endmodule

// File: rtl/cmp_chain_track.sv
module cmp_chain_track
   import cmp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      auth_first,
   input  logic      auth_follow,
   input  logic      fire,
   input  logic      accept,
   input  cmd_kind_e kind,
   input  logic      rsp_req,
   output logic      auth_evt,
   output logic      authed,
   output logic      unverified,
   output logic      warn
);

   assign auth_evt = auth_first || (auth_follow && authed);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         authed     <= 1'b0;
         unverified <= 1'b0;
         warn       <= 1'b0;
      end else if (auth_evt) begin
         authed     <= 1'b1;
         unverified <= 1'b0;
         warn       <= unverified;
      end else begin
         warn <= 1'b0;
         if (fire && accept) begin
            if (rsp_req)
               unverified <= 1'b0;
            else if (kind == CK_READ)
               unverified <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/cmd_mac_policy.sv
module cmd_mac_policy
   import cmp_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid_i,
   input  logic [1:0]       cmd_kind_i,
   input  logic             cmd_mac_i,
   input  logic             rsp_mac_req_i,
   input  logic             plain_i,
   input  logic             blk_plain_ok_i,
   input  logic             allow_unmaced_rd_i,
   input  logic             auth_first_i,
   input  logic             auth_follow_i,
   output logic             res_valid_o,
   output logic [1:0]       res_status_o,
   output logic             res_rsp_mac_o,
   output logic [CNT_W-1:0] txn_count_o,
   output logic             unverified_o,
   output logic             auth_warn_o
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("cmd_mac_policy: CNT_W must lie in 2..32");
      end
   endgenerate

   cmd_req_t req;
   verdict_e verdict;
   logic     accept;
   logic     auth_evt;
   logic     authed_q;
   logic     fire;

   assign req = '{kind:         cmd_kind_e'(cmd_kind_i),
                  cmd_mac:      cmd_mac_i,
                  rsp_req:      rsp_mac_req_i,
                  plain:        plain_i,
                  blk_plain_ok: blk_plain_ok_i};

   assign fire = cmd_valid_i && !auth_evt;

   cmp_rule_eval u_rules (
      .req              (req),
      .authed           (authed_q),
      .allow_unmaced_rd (allow_unmaced_rd_i),
      .verdict          (verdict),
      .accept           (accept)
   );

   cmp_chain_track u_chain (
      .clk         (clk),
      .rst_n       (rst_n),
      .auth_first  (auth_first_i),
      .auth_follow (auth_follow_i),
      .fire        (fire),
      .accept      (accept),
      .kind        (req.kind),
      .rsp_req     (req.rsp_req),
      .auth_evt    (auth_evt),
      .authed      (authed_q),
      .unverified  (unverified_o),
      .warn        (auth_warn_o)
   );

   cmp_txn_counter #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (auth_first_i),
      .inc   (fire && accept),
      .count (txn_count_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid_o   <= 1'b0;
         res_status_o  <= 2'd0;
         res_rsp_mac_o <= 1'b0;
      end else begin
         res_valid_o <= fire;
         if (fire) begin
            res_status_o  <= verdict;
            res_rsp_mac_o <= accept && rsp_mac_req_i;
         end
      end
   end

endmodule

// File: rtl/cmp_checker.sv
module cmp_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid_i,
   input logic [1:0]       cmd_kind_i,
   input logic             cmd_mac_i,
   input logic             auth_first_i,
   input logic             auth_follow_i,
   input logic             authed_q,
   input logic             res_valid_o,
   input logic [1:0]       res_status_o,
   input logic             res_rsp_mac_o,
   input logic [CNT_W-1:0] txn_count_o,
   input logic             unverified_o,
   input logic             auth_warn_o
);

   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   // R2
   p_noauth_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && !auth_first_i && !authed_q) |=> (res_valid_o && res_status_o == 2'd3));

   // R3
   p_mac_required_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && !auth_first_i && !auth_follow_i && authed_q
       && cmd_kind_i != 2'd0 && !cmd_mac_i) |=> (res_valid_o && res_status_o == 2'd1));

   // R6
   p_reject_no_rmac_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_status_o != 2'd0) |-> !res_rsp_mac_o);

   // R7
   p_first_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      auth_first_i |=> (txn_count_o == '0 && !unverified_o));

   // R8
   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_status_o == 2'd0 && $past(txn_count_o) != CMAX)
      |-> txn_count_o == CNT_W'($past(txn_count_o) + 1'b1));

   // R9
   p_mac_clears_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_rsp_mac_o) |-> !unverified_o);

   // R10
   p_warn_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      auth_warn_o |-> $past(unverified_o));

   // R11
   p_collide_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && auth_first_i) |=> !res_valid_o);

endmodule

bind cmd_mac_policy cmp_checker #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid_i   (cmd_valid_i),
   .cmd_kind_i    (cmd_kind_i),
   .cmd_mac_i     (cmd_mac_i),
   .auth_first_i  (auth_first_i),
   .auth_follow_i (auth_follow_i),
   .authed_q      (authed_q),
   .res_valid_o   (res_valid_o),
   .res_status_o  (res_status_o),
   .res_rsp_mac_o (res_rsp_mac_o),
   .txn_count_o   (txn_count_o),
   .unverified_o  (unverified_o),
   .auth_warn_o   (auth_warn_o)
);

// File: tb/cmd_mac_policy_tb.sv
module cmd_mac_policy_tb;

   localparam int CW = 3;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_valid_i, cmd_mac_i, rsp_mac_req_i, plain_i, blk_plain_ok_i;
   logic          allow_unmaced_rd_i, auth_first_i, auth_follow_i;
   logic [1:0]    cmd_kind_i;
   logic          res_valid_o, res_rsp_mac_o, unverified_o, auth_warn_o;
   logic [1:0]    res_status_o;
   logic [CW-1:0] txn_count_o;

   int checks = 0;
   int errors = 0;
   int exp_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cmd_mac_policy #(.CNT_W(CW), .SATURATE(1'b1)) u_dut (.*);

   // {kind[1:0], mac, rsp_req, plain, blk_ok, allow, exp_status[1:0], exp_rmac, exp_unv}
   localparam int NV = 13;
   localparam logic [10:0] VEC [NV] = '{
      11'b00_1_0_0_0_0_00_0_1,  // read MACed, no rsp MAC -> unverified
      11'b00_1_1_0_0_0_00_1_0,  // read with rsp MAC clears
      11'b01_0_1_0_0_0_01_0_0,  // write no MAC
      11'b10_0_0_0_0_0_01_0_0,  // value no MAC
      11'b11_0_1_0_0_0_01_0_0,  // other no MAC
      11'b00_0_0_0_0_0_01_0_0,  // read no MAC, not allowed
      11'b00_0_0_0_0_1_00_0_1,  // read no MAC, allowed
      11'b01_1_1_1_0_0_10_0_1,  // write plain denied
      11'b01_0_0_1_0_0_01_0_1,  // MAC missing wins over plain
      11'b10_1_0_1_0_0_00_0_1,  // value: plain ignored
      11'b00_1_0_1_1_0_00_0_1,  // read plain permitted
      11'b11_1_1_0_0_0_00_1_0,  // other MACed rsp clears
      11'b00_1_1_1_0_0_10_0_0   // read plain denied
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      cmd_valid_i = 0; cmd_kind_i = 0; cmd_mac_i = 0; rsp_mac_req_i = 0;
      plain_i = 0; blk_plain_ok_i = 0; allow_unmaced_rd_i = 0;
      auth_first_i = 0; auth_follow_i = 0;
   endtask

   task automatic do_cmd(input logic [1:0] k, input logic m, input logic rq,
                         input logic p, input logic b, input logic a);
      @(negedge clk);
      cmd_valid_i = 1; cmd_kind_i = k; cmd_mac_i = m; rsp_mac_req_i = rq;
      plain_i = p; blk_plain_ok_i = b; allow_unmaced_rd_i = a;
      @(negedge clk);
      idle();
   endtask

   task automatic do_auth(input logic first, input logic follow);
      @(negedge clk);
      auth_first_i = first; auth_follow_i = follow;
      @(negedge clk);
      idle();
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      chk("R1 count", txn_count_o, 0);
      chk("R1 unverified", unverified_o, 0);
      chk("R1 res_valid", res_valid_o, 0);
      chk("R1 warn", auth_warn_o, 0);

      // R2: before authentication
      do_cmd(2'd1, 1, 0, 0, 0, 0);
      chk("R12 res_valid", res_valid_o, 1);
      chk("R2 status", res_status_o, 3);
      chk("R2 count", txn_count_o, 0);
      @(negedge clk);
      chk("R12 single pulse", res_valid_o, 0);

      // R7: following auth while unauthenticated is ignored
      do_auth(0, 1);
      do_cmd(2'd0, 1, 0, 0, 0, 0);
      chk("R7 follow ignored", res_status_o, 3);

      do_auth(1, 0);
      chk("R7 first count", txn_count_o, 0);
      exp_cnt = 0;

      for (int i = 0; i < NV; i++) begin
         do_cmd(VEC[i][10:9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
         if (VEC[i][3:2] == 2'd0 && exp_cnt < CMAX) exp_cnt++;
         chk($sformatf("R3 R4 R5 status v%0d", i), res_status_o, VEC[i][3:2]);
         chk($sformatf("R6 rsp_mac v%0d", i), res_rsp_mac_o, VEC[i][1]);
         chk($sformatf("R9 unverified v%0d", i), unverified_o, VEC[i][0]);
         chk($sformatf("R8 count v%0d", i), txn_count_o, exp_cnt);
      end

      // R8 saturation: push two more accepted commands
      do_cmd(2'd1, 1, 1, 0, 0, 0);
      chk("R8 reach max", txn_count_o, CMAX);
      do_cmd(2'd1, 1, 1, 0, 0, 0);
      chk("R8 saturate", txn_count_o, CMAX);

      // R10: unverified then following authentication
      do_cmd(2'd0, 1, 0, 0, 0, 0);
      chk("R9 set", unverified_o, 1);
      do_auth(0, 1);
      chk("R10 warn", auth_warn_o, 1);
      chk("R7 follow keeps count", txn_count_o, CMAX);
      chk("R7 follow clears flag", unverified_o, 0);
      @(negedge clk);
      chk("R10 warn one cycle", auth_warn_o, 0);

      // R10: no warning when nothing is unverified
      do_auth(1, 0);
      chk("R10 no warn", auth_warn_o, 0);
      chk("R7 first clears count", txn_count_o, 0);

      // R11: command alongside first authentication is dropped
      @(negedge clk);
      cmd_valid_i = 1; cmd_kind_i = 2'd1; cmd_mac_i = 1; auth_first_i = 1;
      @(negedge clk);
      idle();
      chk("R11 dropped", res_valid_o, 0);
      chk("R11 count", txn_count_o, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule